// File: doc/BRIEF.md
# Management Bus Register Responder (PHY Side)

This block is the device end of a two-wire serial management bus of the kind used between an Ethernet MAC and its PHYs. It runs directly from the management clock. It watches the shared data line and locks onto a frame only after a full run of ones followed by the start pattern. It decodes the operation and the two 5-bit address fields. On a write it stores the 16-bit payload in a local bank of thirty-two 16-bit registers. On a read it takes over the line partway through the turnaround and shifts a register out. The pad is split into a sampled input, a data-out and an output-enable, which the chip ties to a tristate buffer with an external pull-up.

The PHY address comes from strap pins. Address 0 is a broadcast address. Broadcast writes land in the bank, but broadcast reads are never answered, so that several responders on one line cannot fight each other. A parameter mask marks some registers as read-only. Those registers return a live status input and ignore writes.

The frame state machine has these states:
- `ST_HUNT` counts consecutive ones.
- `ST_SOF` expects the second start bit.
- `ST_OPC` takes the 2-bit operation.
- `ST_ADR` takes the 10 address bits.
- `ST_TA0` and `ST_TA1` cover the turnaround.
- `ST_WDAT` takes the write payload.
- `ST_RDAT` shifts out the read payload.

Its transitions are:
- `HUNT→SOF` on a 0 after at least `PRE_LEN` ones.
- `SOF→OPC` on a 1.
- `SOF→HUNT` on a 0.
- `OPC→ADR` on a read or write code.
- `OPC→HUNT` on any other code.
- `ADR→TA0` after 10 bits.
- `TA0→TA1` on a read, or on a write whose first turnaround bit is 1.
- `TA0→HUNT` on a write whose first turnaround bit is 0.
- `TA1→RDAT` on a read.
- `TA1→WDAT` on a write whose second turnaround bit is 0.
- `TA1→HUNT` on a write whose second turnaround bit is 1.
- `WDAT→HUNT` after 16 bits.
- `RDAT→HUNT` after the last bit is released.

Top module: `mdio_resp`

## Requirements
- R1: After reset `mdio_oe` is 0 and every read/write register holds 0.
- R2: A frame is ignored when fewer than `PRE_LEN` (32) consecutive ones precede the start pattern 0,1.
- R3: A preamble longer than `PRE_LEN` ones is accepted.
- R4: A write uses operation code 01, with bits sent in line order: start 0,1, operation, PHY address MSB first, register address MSB first, turnaround 1,0, then 16 data bits MSB first. When it is addressed to the strapped PHY address, it updates the selected register.
- R5: A read uses operation code 10. When it is addressed to the strapped address, the line is undriven during the first turnaround bit. The block drives 0 during the second turnaround bit, then drives the 16 register bits MSB first, and then releases the line. `mdio_oe` is high for exactly 17 bit periods and never while the master drives.
- R6: A frame carrying another non-zero PHY address leaves the line undriven and the bank unchanged.
- R7: A write to PHY address 0 updates the bank. A read from PHY address 0 is never driven.
- R8: A write whose turnaround is not 1,0 is discarded.
- R9: Operation codes 00 and 11 are discarded, and the next valid frame is handled normally.
- R10: A register whose bit is set in `RO_MAP` (default: register 1) reads back `sts_in` and ignores writes.
- R11: Line bits are sampled on the rising clock edge. Driven bits change just after a rising edge, one edge after the bit that precedes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Management clock; line sampled on rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_addr | input | 5 | Strapped PHY address of this responder |
| sts_in | input | 16 | Live status word returned by read-only registers |
| mdio_in | input | 1 | Sampled level of the shared data line |
| mdio_oe | output | 1 | Enable for the tristate pad driver |
| mdio_out | output | 1 | Value driven when `mdio_oe` is high |

## Verification
The bench drives the master's bits on the falling edge, so each bit is sampled at the following rising edge. It reads the line one falling edge after every driven change. On a read, the enable must still be low in the falling-edge sample inside the first turnaround period. It must be high with a 0 one period later, once the rising edge that samples the first turnaround bit has passed. Data bit 15 then appears in the next period and bit 0 sixteen periods after the turnaround zero. The release must show in the period that follows. A write takes effect at the rising edge that samples its last data bit, so every write is confirmed through a later read frame rather than by looking inside the bank.

// File: rtl/mdio_resp_pkg.sv
package mdio_resp_pkg;
    localparam int ADDR_W = 5;
    localparam int DATA_W = 16;
    localparam int NREG   = 1 << ADDR_W;
    localparam int HDR_W  = 2 * ADDR_W;

    localparam logic [1:0] OP_RD = 2'b10;
    localparam logic [1:0] OP_WR = 2'b01;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_SOF,
        ST_OPC,
        ST_ADR,
        ST_TA0,
        ST_TA1,
        ST_WDAT,
        ST_RDAT
    } fsm_st_t;
endpackage

// File: rtl/mdio_resp_regbank.sv
module mdio_resp_regbank
    import mdio_resp_pkg::*;
#(
    parameter logic [NREG-1:0] RO_MAP = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] sts_in,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] word [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        if (RO_MAP[i]) begin : g_ro
            assign word[i] = sts_in;
        end else begin : g_rw
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= '0;
                else if (wr_en && wr_addr == ADDR_W'(i))
                    q <= wr_data;
            end
            assign word[i] = q;
        end
    end

    assign rd_data = word[rd_addr];
endmodule

// File: rtl/mdio_resp_fsm.sv
module mdio_resp_fsm
    import mdio_resp_pkg::*;
#(
    parameter int PRE_LEN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              din,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] reg_addr,
    output logic              wr_en,
    output logic [DATA_W-1:0] wr_data,
    output logic              oe,
    output logic              dout,
    output fsm_st_t           state_o
);
    localparam int CNT_W = $clog2(PRE_LEN + DATA_W + 1);
    localparam logic [CNT_W-1:0] PRE_C  = CNT_W'(PRE_LEN);
    localparam logic [CNT_W-1:0] LAST_D = CNT_W'(DATA_W - 1);
    localparam logic [CNT_W-1:0] LAST_A = CNT_W'(HDR_W - 1);

    fsm_st_t           state, nxt;
    logic [CNT_W-1:0]  cnt, cnt_n;
    logic [1:0]        op, op_n;
    logic [HDR_W-1:0]  adr, adr_n;
    logic [DATA_W-1:0] sh, sh_n;
    logic [ADDR_W-1:0] pa;
    logic              is_rd, hit_rd, hit_wr;

    assign pa       = adr[HDR_W-1:ADDR_W];
    assign reg_addr = adr[ADDR_W-1:0];
    assign is_rd    = (op == OP_RD);
    assign hit_rd   = (pa == phy_addr) && (pa != '0);
    assign hit_wr   = (pa == phy_addr) || (pa == '0);
    assign wr_data  = {sh[DATA_W-2:0], din};
    assign state_o  = state;

    always_comb begin
        nxt   = state;
        cnt_n = cnt;
        op_n  = op;
        adr_n = adr;
        sh_n  = sh;
        wr_en = 1'b0;
        unique case (state)
            ST_HUNT: begin
                if (din) begin
                    if (cnt != PRE_C) cnt_n = cnt + 1'b1;
                end else begin
                    cnt_n = '0;
                    if (cnt == PRE_C) nxt = ST_SOF;
                end
            end
            ST_SOF: begin
                cnt_n = '0;
                nxt   = din ? ST_OPC : ST_HUNT;
            end
            ST_OPC: begin
                op_n  = {op[0], din};
                cnt_n = cnt + 1'b1;
                if (cnt == CNT_W'(1)) begin
                    cnt_n = '0;
                    nxt   = ({op[0], din} == OP_RD || {op[0], din} == OP_WR)
                            ? ST_ADR : ST_HUNT;
                end
            end
            ST_ADR: begin
                adr_n = {adr[HDR_W-2:0], din};
                cnt_n = cnt + 1'b1;
                if (cnt == LAST_A) begin
                    cnt_n = '0;
                    nxt   = ST_TA0;
                end
            end
            ST_TA0: begin
                if (is_rd) begin
                    sh_n = rd_data;
                    nxt  = ST_TA1;
                end else begin
                    nxt = din ? ST_TA1 : ST_HUNT;
                end
            end
            ST_TA1: begin
                if (is_rd) begin
                    sh_n  = {sh[DATA_W-2:0], 1'b0};
                    cnt_n = LAST_D;
                    nxt   = ST_RDAT;
                end else begin
                    nxt = din ? ST_HUNT : ST_WDAT;
                end
            end
            ST_WDAT: begin
                sh_n  = {sh[DATA_W-2:0], din};
                cnt_n = cnt + 1'b1;
                if (cnt == LAST_D) begin
                    wr_en = hit_wr;
                    cnt_n = '0;
                    nxt   = ST_HUNT;
                end
            end
            ST_RDAT: begin
                if (cnt == '0) begin
                    nxt = ST_HUNT;
                end else begin
                    cnt_n = cnt - 1'b1;
                    sh_n  = {sh[DATA_W-2:0], 1'b0};
                end
            end
            default: nxt = ST_HUNT;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_HUNT;
            cnt   <= '0;
            op    <= '0;
            adr   <= '0;
            sh    <= '0;
        end else begin
            state <= nxt;
            cnt   <= cnt_n;
            op    <= op_n;
            adr   <= adr_n;
            sh    <= sh_n;
        end
    end

    // pad outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            oe   <= 1'b0;
            dout <= 1'b0;
        end else begin
            unique case (state)
                ST_TA0: begin
                    oe   <= is_rd && hit_rd;
                    dout <= 1'b0;
                end
                ST_TA1: dout <= sh[DATA_W-1];
                ST_RDAT: begin
                    if (cnt == '0) begin
                        oe   <= 1'b0;
                        dout <= 1'b0;
                    end else begin
                        dout <= sh[DATA_W-1];
                    end
                end
                default: begin
                    oe   <= 1'b0;
                    dout <= 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/mdio_resp.sv
module mdio_resp
    import mdio_resp_pkg::*;
#(
    parameter int              PRE_LEN = 32,
    parameter logic [NREG-1:0] RO_MAP  = NREG'(2)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] phy_addr,
    input  logic [DATA_W-1:0] sts_in,
    input  logic              mdio_in,
    output logic              mdio_oe,
    output logic              mdio_out
);
    logic [ADDR_W-1:0] reg_addr;
    logic [DATA_W-1:0] rd_data, wr_data;
    logic              wr_en;
    fsm_st_t           fsm_state;

    mdio_resp_fsm #(.PRE_LEN(PRE_LEN)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .din      (mdio_in),
        .phy_addr (phy_addr),
        .rd_data  (rd_data),
        .reg_addr (reg_addr),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .oe       (mdio_oe),
        .dout     (mdio_out),
        .state_o  (fsm_state)
    );

    mdio_resp_regbank #(.RO_MAP(RO_MAP)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (reg_addr),
        .wr_data (wr_data),
        .rd_addr (reg_addr),
        .sts_in  (sts_in),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/mdio_resp_chk.sv
module mdio_resp_chk
    import mdio_resp_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    oe,
    input logic    dout,
    input fsm_st_t st
);
    localparam int WIN   = DATA_W + 1;
    localparam int RUN_W = $clog2(WIN + 2);

    logic [RUN_W-1:0] run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            run <= '0;
        else if (!oe)
            run <= '0;
        else if (run != {RUN_W{1'b1}})
            run <= run + 1'b1;
    end

    // R5: driver only enabled in the read turnaround/data phase
    p_oe_in_read_phase_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> (st == ST_TA1 || st == ST_RDAT));

    // R5: first driven bit is the turnaround zero
    p_ta_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> !dout);

    // R11: driving starts on the edge after the first turnaround bit
    p_drive_start_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(oe) |-> $past(st) == ST_TA0);

    // R5: no driven window exceeds 17 bit periods
    p_window_max_r5: assert property (@(posedge clk) disable iff (!rst_n)
        oe |-> run < RUN_W'(WIN));

    // R5: every driven window lasts exactly 17 bit periods
    p_window_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe) |-> run == RUN_W'(WIN));
endmodule

bind mdio_resp mdio_resp_chk u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .oe    (mdio_oe),
    .dout  (mdio_out),
    .st    (fsm_state)
);

// File: tb/mdio_resp_tb_top.sv
module mdio_resp_tb_top;
    localparam logic [4:0] MY_PA = 5'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sts = 16'hBEEF;
    logic        m_oe = 1'b0;
    logic        m_bit = 1'b1;
    logic        dut_oe, dut_out;
    wire         line = dut_oe ? dut_out : (m_oe ? m_bit : 1'b1);

    int n_chk = 0;
    int n_fail = 0;
    int n_contend = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    mdio_resp dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .phy_addr (MY_PA),
        .sts_in   (sts),
        .mdio_in  (line),
        .mdio_oe  (dut_oe),
        .mdio_out (dut_out)
    );

    always @(negedge clk) if (m_oe && dut_oe) n_contend++;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        @(negedge clk);
        m_oe  = 1'b1;
        m_bit = b;
    endtask

    task automatic send_hdr(input int pre, input logic [1:0] op, input logic [4:0] pa, input logic [4:0] ra);
        for (int i = 0; i < pre; i++) send_bit(1'b1);
        send_bit(1'b0);
        send_bit(1'b1);
        send_bit(op[1]);
        send_bit(op[0]);
        for (int i = 4; i >= 0; i--) send_bit(pa[i]);
        for (int i = 4; i >= 0; i--) send_bit(ra[i]);
    endtask

    task automatic wr_frame(input int pre, input logic [1:0] op, input logic [4:0] pa,
                            input logic [4:0] ra, input logic [1:0] ta, input logic [15:0] d);
        send_hdr(pre, op, pa, ra);
        send_bit(ta[1]);
        send_bit(ta[0]);
        for (int i = 15; i >= 0; i--) send_bit(d[i]);
        @(negedge clk);
        m_oe = 1'b0;
    endtask

    task automatic rd_frame(input logic [4:0] pa, input logic [4:0] ra, input bit drive,
                            input logic [15:0] exp, input string tag);
        logic [15:0] got;
        bit all_on;
        got = '0;
        all_on = 1'b1;
        send_hdr(32, 2'b10, pa, ra);
        @(negedge clk);
        m_oe = 1'b0;
        chk(!dut_oe, {tag, " first turnaround undriven (R5)"}, 32'(dut_oe), 0);
        @(negedge clk);
        if (drive)
            chk(dut_oe && !dut_out, {tag, " second turnaround driven 0 (R5/R11)"}, {dut_oe, dut_out}, 32'b10);
        else
            chk(!dut_oe, {tag, " turnaround stays undriven"}, 32'(dut_oe), 0);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            got = {got[14:0], line};
            if (dut_oe != drive) all_on = 1'b0;
        end
        chk(all_on && got == (drive ? exp : 16'hFFFF), {tag, " data word"},
            got, drive ? exp : 16'hFFFF);
        @(negedge clk);
        chk(!dut_oe, {tag, " line released (R5)"}, 32'(dut_oe), 0);
    endtask

    task automatic t_reset;
        chk(!dut_oe, "R1 oe low in reset", 32'(dut_oe), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!dut_oe, "R1 oe low after reset", 32'(dut_oe), 0);
        rd_frame(MY_PA, 5'd5, 1'b1, 16'h0000, "R1 reg5 reset value");
    endtask

    task automatic t_write_read;
        wr_frame(32, 2'b01, MY_PA, 5'd3, 2'b10, 16'hA5C3);
        rd_frame(MY_PA, 5'd3, 1'b1, 16'hA5C3, "R4 R5 reg3 write/read");
        wr_frame(32, 2'b01, MY_PA, 5'd31, 2'b10, 16'h8001);
        rd_frame(MY_PA, 5'd31, 1'b1, 16'h8001, "R4 reg31 edge bits");
    endtask

    task automatic t_long_pre;
        wr_frame(45, 2'b01, MY_PA, 5'd4, 2'b10, 16'h1234);
        rd_frame(MY_PA, 5'd4, 1'b1, 16'h1234, "R3 long preamble");
    endtask

    task automatic t_short_pre;
        send_bit(1'b0);
        send_bit(1'b0);
        wr_frame(31, 2'b01, MY_PA, 5'd6, 2'b10, 16'hFFFF);
        rd_frame(MY_PA, 5'd6, 1'b1, 16'h0000, "R2 short preamble ignored");
    endtask

    task automatic t_other;
        wr_frame(32, 2'b01, 5'd9, 5'd3, 2'b10, 16'h0000);
        rd_frame(5'd9, 5'd3, 1'b0, 16'h0000, "R6 foreign read");
        rd_frame(MY_PA, 5'd3, 1'b1, 16'hA5C3, "R6 foreign write ignored");
    endtask

    task automatic t_bcast;
        wr_frame(32, 2'b01, 5'd0, 5'd8, 2'b10, 16'h0F0F);
        rd_frame(MY_PA, 5'd8, 1'b1, 16'h0F0F, "R7 broadcast write");
        rd_frame(5'd0, 5'd8, 1'b0, 16'h0000, "R7 broadcast read undriven");
    endtask

    task automatic t_bad_ta;
        wr_frame(32, 2'b01, MY_PA, 5'd3, 2'b11, 16'h1111);
        wr_frame(32, 2'b01, MY_PA, 5'd3, 2'b00, 16'h2222);
        rd_frame(MY_PA, 5'd3, 1'b1, 16'hA5C3, "R8 bad turnaround discarded");
    endtask

    task automatic t_bad_op;
        wr_frame(32, 2'b11, MY_PA, 5'd3, 2'b10, 16'h3333);
        wr_frame(32, 2'b00, MY_PA, 5'd3, 2'b10, 16'h4444);
        rd_frame(MY_PA, 5'd3, 1'b1, 16'hA5C3, "R9 unknown opcode discarded");
        wr_frame(32, 2'b01, MY_PA, 5'd10, 2'b10, 16'hC0DE);
        rd_frame(MY_PA, 5'd10, 1'b1, 16'hC0DE, "R9 recovery after bad opcode");
    endtask

    task automatic t_ro;
        rd_frame(MY_PA, 5'd1, 1'b1, 16'hBEEF, "R10 status read");
        wr_frame(32, 2'b01, MY_PA, 5'd1, 2'b10, 16'h0000);
        rd_frame(MY_PA, 5'd1, 1'b1, 16'hBEEF, "R10 write to status ignored");
        sts = 16'h1357;
        rd_frame(MY_PA, 5'd1, 1'b1, 16'h1357, "R10 status tracks input");
    endtask

    initial begin
        t_reset();
        t_write_read();
        t_long_pre();
        t_short_pre();
        t_other();
        t_bcast();
        t_bad_ta();
        t_bad_op();
        t_ro();
        chk(n_contend == 0, "R5 no drive while master drives", n_contend, 0);
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end
endmodule